// File: doc/BRIEF.md
# Repeat-Copy Micro-op Expander

This block turns one repeated string-copy instruction into a stream of copy micro-ops without a branch micro-op between iterations. When started, it issues a fixed first batch of copy micro-ops. Each one is predicated on its own iteration index, and the execute stage cancels any whose index is not below the real repeat count. The unit does not wait for that outcome. After the batch it issues one count-fetch micro-op and then stalls. The execute stage returns the actual repeat count on a feedback port.

With that count, the unit issues exactly the copy iterations still missing. These are unpredicated and carry consecutive indices. No branch micro-op is placed between them. A returned count of zero takes a separate path: one cancel-all micro-op is issued so that every batch copy is discarded. The issue port may apply back-pressure in any cycle.

Top module: `rce_expander`

## Requirements
- R1: After reset the unit is idle: `busy_o` is 0 and `uop_valid_o` is 0.
- R2: A `start_i` pulse while idle makes the next `BATCH_N` issued micro-ops copies (kind 2'd0) with `uop_pred_o`=1 and indices 0 to `BATCH_N`-1 in ascending order. `busy_o` rises in the cycle after the pulse.
- R3: The batch is followed by exactly one count-fetch micro-op (kind 2'd1) with index 0 and predicate 0.
- R4: After the count-fetch is accepted, no micro-op is issued and `busy_o` stays 1 until `fb_valid_i` is seen.
- R5: A returned count from 1 to `BATCH_N` ends the flow with no further micro-ops. `busy_o` falls in the cycle after feedback.
- R6: A returned count C greater than `BATCH_N` yields exactly C-`BATCH_N` copy micro-ops with `uop_pred_o`=0 and indices `BATCH_N` to C-1 ascending, and then the unit is idle. The count is unsigned.
- R7: A returned count of 0 yields exactly one cancel-all micro-op (kind 2'd2, index 0, predicate 0), and then the unit is idle.
- R8: While `uop_valid_o`=1 and `uop_ready_i`=0, every micro-op output holds its value into the next cycle.
- R9: `start_i` while busy, and `fb_valid_i` outside the wait for the count, have no effect on issued micro-ops or on `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin expanding one repeated copy |
| uop_ready_i | input | 1 | Issue port accepts the offered micro-op |
| fb_valid_i | input | 1 | Repeat count from execute is valid |
| fb_count_i | input | CNT_W | Actual repeat count, unsigned |
| busy_o | output | 1 | Expansion in progress |
| uop_valid_o | output | 1 | A micro-op is offered |
| uop_kind_o | output | 2 | 0 copy, 1 count-fetch, 2 cancel-all |
| uop_idx_o | output | CNT_W | Iteration index of a copy, 0 otherwise |
| uop_pred_o | output | 1 | Copy is predicated on index < count |

## Verification
The flow is exercised with returned counts of 0, 1, 3, exactly `BATCH_N`, `BATCH_N`+1, and well above `BATCH_N`. Together these separate the cancel-all path, the end without a tail, and the tail-length arithmetic at its off-by-one edges. The issue port is driven always ready, ready every other cycle, and ready two cycles out of three, which shows that indices neither skip nor repeat under back-pressure. Stray start pulses during a flow and stray feedback while idle or mid-batch show that neither one disturbs the stream.

// File: rtl/rce_pkg.sv
package rce_pkg;
    typedef enum logic [1:0] {
        K_COPY   = 2'd0,
        K_FETCH  = 2'd1,
        K_CANCEL = 2'd2
    } uop_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BATCH,
        S_FETCH,
        S_WAIT,
        S_TAIL,
        S_CANCEL
    } phase_e;
endpackage

// File: rtl/rce_remain_calc.sv
module rce_remain_calc #(
    parameter int CNT_W   = 32,
    parameter int BATCH_N = 8
) (
    input  logic [CNT_W-1:0] count_i,
    output logic             is_zero_o,
    output logic             has_tail_o,
    output logic [CNT_W-1:0] tail_last_o
);
    localparam logic [CNT_W-1:0] BN = CNT_W'(BATCH_N);

    always_comb begin
        is_zero_o   = (count_i == '0);
        has_tail_o  = (count_i > BN);
        tail_last_o = count_i - CNT_W'(1);
    end
endmodule

// File: rtl/rce_seq.sv
module rce_seq
    import rce_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BATCH_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ready_i,
    input  logic             fb_valid_i,
    input  logic             is_zero_i,
    input  logic             has_tail_i,
    input  logic [CNT_W-1:0] tail_last_i,
    output phase_e           phase_o,
    output logic [CNT_W-1:0] idx_o
);
    localparam logic [CNT_W-1:0] BN     = CNT_W'(BATCH_N);
    localparam logic [CNT_W-1:0] B_LAST = CNT_W'(BATCH_N - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] last;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            S_IDLE: if (start_i) begin
                st_d.phase = S_BATCH;
                st_d.idx   = '0;
            end
            S_BATCH: if (ready_i) begin
                if (st_q.idx == B_LAST) begin
                    st_d.phase = S_FETCH;
                    st_d.idx   = '0;
                end else begin
                    st_d.idx = st_q.idx + CNT_W'(1);
                end
            end
            S_FETCH: if (ready_i) st_d.phase = S_WAIT;
            S_WAIT: if (fb_valid_i) begin
                if (is_zero_i) begin
                    st_d.phase = S_CANCEL;
                end else if (has_tail_i) begin
                    st_d.phase = S_TAIL;
                    st_d.idx   = BN;
                    st_d.last  = tail_last_i;
                end else begin
                    st_d.phase = S_IDLE;
                end
            end
            S_TAIL: if (ready_i) begin
                if (st_q.idx == st_q.last) begin
                    st_d.phase = S_IDLE;
                    st_d.idx   = '0;
                end else begin
                    st_d.idx = st_q.idx + CNT_W'(1);
                end
            end
            S_CANCEL: if (ready_i) st_d.phase = S_IDLE;
            default: st_d.phase = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: S_IDLE, idx: '0, last: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign idx_o   = st_q.idx;

    logic emitting;
    assign emitting = (st_q.phase == S_BATCH) || (st_q.phase == S_FETCH) ||
                      (st_q.phase == S_TAIL)  || (st_q.phase == S_CANCEL);

    a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        emitting && !ready_i |=> $stable(st_q.phase) && $stable(st_q.idx));

    a_r4_wait_until_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == S_WAIT && !fb_valid_i |=> st_q.phase == S_WAIT);

    a_r2_batch_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == S_BATCH && ready_i && st_q.idx != B_LAST
        |=> st_q.phase == S_BATCH && st_q.idx == $past(st_q.idx) + CNT_W'(1));

    a_r3_fetch_after_batch: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == S_BATCH && ready_i && st_q.idx == B_LAST |=> st_q.phase == S_FETCH);

    a_r7_cancel_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == S_WAIT && fb_valid_i && is_zero_i |=> st_q.phase == S_CANCEL);
endmodule

// File: rtl/rce_uop_fmt.sv
module rce_uop_fmt
    import rce_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  phase_e           phase_i,
    input  logic [CNT_W-1:0] idx_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic [1:0]       kind_o,
    output logic [CNT_W-1:0] idx_o,
    output logic             pred_o
);
    always_comb begin
        busy_o  = (phase_i != S_IDLE);
        valid_o = 1'b0;
        kind_o  = K_COPY;
        idx_o   = '0;
        pred_o  = 1'b0;
        case (phase_i)
            S_BATCH: begin
                valid_o = 1'b1;
                idx_o   = idx_i;
                pred_o  = 1'b1;
            end
            S_TAIL: begin
                valid_o = 1'b1;
                idx_o   = idx_i;
            end
            S_FETCH: begin
                valid_o = 1'b1;
                kind_o  = K_FETCH;
            end
            S_CANCEL: begin
                valid_o = 1'b1;
                kind_o  = K_CANCEL;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rce_expander.sv
module rce_expander
    import rce_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BATCH_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             uop_ready_i,
    input  logic             fb_valid_i,
    input  logic [CNT_W-1:0] fb_count_i,
    output logic             busy_o,
    output logic             uop_valid_o,
    output logic [1:0]       uop_kind_o,
    output logic [CNT_W-1:0] uop_idx_o,
    output logic             uop_pred_o
);
    logic             is_zero, has_tail;
    logic [CNT_W-1:0] tail_last, seq_idx;
    phase_e           phase;

    rce_remain_calc #(.CNT_W(CNT_W), .BATCH_N(BATCH_N)) u_calc (
        .count_i    (fb_count_i),
        .is_zero_o  (is_zero),
        .has_tail_o (has_tail),
        .tail_last_o(tail_last)
    );

    rce_seq #(.CNT_W(CNT_W), .BATCH_N(BATCH_N)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ready_i    (uop_ready_i),
        .fb_valid_i (fb_valid_i),
        .is_zero_i  (is_zero),
        .has_tail_i (has_tail),
        .tail_last_i(tail_last),
        .phase_o    (phase),
        .idx_o      (seq_idx)
    );

    rce_uop_fmt #(.CNT_W(CNT_W)) u_fmt (
        .phase_i(phase),
        .idx_i  (seq_idx),
        .busy_o (busy_o),
        .valid_o(uop_valid_o),
        .kind_o (uop_kind_o),
        .idx_o  (uop_idx_o),
        .pred_o (uop_pred_o)
    );

    a_r6_tail_unpredicated: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid_o && uop_kind_o == 2'd0 && uop_idx_o >= CNT_W'(BATCH_N) |-> !uop_pred_o);

    a_r9_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && uop_valid_o && !uop_ready_i |=> busy_o);
endmodule

// File: tb/rce_expander_bench.sv
module rce_expander_bench;
    localparam int CNT_W   = 32;
    localparam int BATCH_N = 8;

    typedef struct {
        int kind;
        int idx;
        int pred;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             uop_ready_i = 1'b1;
    logic             fb_valid_i = 1'b0;
    logic [CNT_W-1:0] fb_count_i = '0;
    logic             busy_o, uop_valid_o, uop_pred_o;
    logic [1:0]       uop_kind_o;
    logic [CNT_W-1:0] uop_idx_o;

    always #2 clk = ~clk;

    rce_expander #(.CNT_W(CNT_W), .BATCH_N(BATCH_N)) u_rce_expander (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .uop_ready_i(uop_ready_i),
        .fb_valid_i(fb_valid_i), .fb_count_i(fb_count_i), .busy_o(busy_o),
        .uop_valid_o(uop_valid_o), .uop_kind_o(uop_kind_o), .uop_idx_o(uop_idx_o),
        .uop_pred_o(uop_pred_o)
    );

    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t q[$];
    bit   m_busy = 0;
    bit   m_wait = 0;
    int   ready_mode = 0;
    int   cyc = 0;
    bit   prev_stall = 0;
    logic [1:0]       prev_kind;
    logic [CNT_W-1:0] prev_idx;
    logic             prev_pred;

    task automatic chk(bit ok, string req, string what, longint act, longint exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    // Reference model, evaluated every cycle away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy_o == m_busy, m_wait ? "R4" : "R5", "busy", busy_o, m_busy);
            if (prev_stall) begin
                chk(uop_kind_o == prev_kind && uop_idx_o == prev_idx && uop_pred_o == prev_pred,
                    "R8", "held record idx", uop_idx_o, prev_idx);
            end
            if (q.size() == 0) begin
                chk(uop_valid_o == 1'b0, m_wait ? "R4" : "R9", "unexpected valid", uop_valid_o, 0);
            end else begin
                chk(uop_valid_o == 1'b1, "R2", "valid", uop_valid_o, 1);
                if (uop_valid_o) begin
                    chk(int'(uop_kind_o) == q[0].kind,
                        q[0].kind == 2 ? "R7" : (q[0].kind == 1 ? "R3" : "R2"),
                        "kind", uop_kind_o, q[0].kind);
                    chk(int'(uop_idx_o) == q[0].idx, q[0].idx >= BATCH_N ? "R6" : "R2",
                        "index", uop_idx_o, q[0].idx);
                    chk(int'(uop_pred_o) == q[0].pred, q[0].pred == 1 ? "R2" : "R6",
                        "predicate", uop_pred_o, q[0].pred);
                    if (uop_ready_i) begin
                        if (q[0].kind == 1) m_wait = 1;
                        void'(q.pop_front());
                        if (q.size() == 0 && !m_wait) m_busy = 0;
                    end
                end
            end
            prev_stall = uop_valid_o && !uop_ready_i;
            prev_kind  = uop_kind_o;
            prev_idx   = uop_idx_o;
            prev_pred  = uop_pred_o;
            if (start_i && !m_busy) begin
                for (int i = 0; i < BATCH_N; i++) q.push_back('{0, i, 1});
                q.push_back('{1, 0, 0});
                m_busy = 1;
            end
            if (fb_valid_i && m_wait) begin
                m_wait = 0;
                if (fb_count_i == 0) q.push_back('{2, 0, 0});
                else for (int i = BATCH_N; i < int'(fb_count_i); i++) q.push_back('{0, i, 0});
                if (q.size() == 0) m_busy = 0;
            end
        end
    end

    // Ready pattern driver
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            case (ready_mode)
                1: uop_ready_i = cyc[0];
                2: uop_ready_i = (cyc % 3) != 0;
                default: uop_ready_i = 1'b1;
            endcase
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic run(int count, int mode);
        ready_mode = mode;
        start_i = 1'b1; step(1); start_i = 1'b0;
        step(2);
        start_i = 1'b1; fb_valid_i = 1'b1; fb_count_i = 32'd5;   // R9 stray inputs mid-batch
        step(1);
        start_i = 1'b0; fb_valid_i = 1'b0;
        while (!m_wait) step(1);
        step(4);                                                 // R4 hold in wait
        fb_count_i = count; fb_valid_i = 1'b1; step(1); fb_valid_i = 1'b0;
        while (m_busy) step(1);
        step(2);
        fb_valid_i = 1'b1; fb_count_i = 32'd30; step(1); fb_valid_i = 1'b0;  // R9 while idle
        step(3);
    endtask

    initial begin
        step(3);
        // R1 reset state
        chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        chk(uop_valid_o == 1'b0, "R1", "valid after reset", uop_valid_o, 0);
        rst_n = 1'b1;
        step(2);
        run(0, 0);             // R7
        run(3, 0);             // R5
        run(1, 1);             // R5
        run(BATCH_N, 2);       // R5 edge
        run(BATCH_N + 1, 0);   // R6 edge
        run(20, 1);            // R6 with stalls
        run(37, 2);            // R6 long tail
        run(0, 1);             // R7 with stalls
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule